// File: doc/BRIEF.md
# Dual-Strobe Burst Address Sequencer

This block produces the word address for a synchronous burst memory. A starting address enters the block on one of two active-low load strobes.

- **Processor strobe.** A load on this strobe needs the master enable to be active.
- **Controller strobe.** A load on this strobe ignores the master enable. It is accepted only when the processor strobe is idle on the same edge.

After a load, an active-low advance input walks the two low-order address bits through a four-beat group. The upper bits are held.

A static mode input picks the step order:

- **Interleaved:** the base bits XOR a beat counter.
- **Linear:** the base bits plus the beat counter, modulo four.

When advance is released, the current address is held. Two one-cycle flags report whether the previous edge loaded a new address or stepped the burst.

All state changes on the rising clock edge. The address output follows the registered base and counter combinationally, so it is valid in the cycle after the edge that produced it.

Top module: `burst_addr_seq`

## Requirements
- R1: When procStrobeN=0 and masterEnN=0 at an edge, accessAddr equals extAddr in the following cycle.
- R2: When masterEnN=1, procStrobeN=0 never loads. With procStrobeN=1 and masterEnN=1, ctrlStrobeN=0 still loads extAddr.
- R3: ctrlStrobeN=0 loads only when procStrobeN=1 on the same edge. With procStrobeN=0 and masterEnN=1, nothing loads and accessAddr is unchanged.
- R4: advanceN is ignored on an edge that loads through the processor strobe. The next accessAddr is exactly extAddr, not its successor.
- R5: The beat counter steps only when advanceN=0, procStrobeN=1 and ctrlStrobeN=1. Otherwise, with no load, accessAddr holds.
- R6: With interleaveMode=1, accessAddr[1:0] = base[1:0] XOR beat, where beat counts 0,1,2,3 from the load.
- R7: With interleaveMode=0, accessAddr[1:0] = (base[1:0] + beat) mod 4.
- R8: accessAddr[ADDR_W-1:2] keeps the loaded value throughout a burst. Steps beyond the fourth beat wrap within the same four-word group with no carry.
- R9: Synchronous active-high rst clears the base and the beat counter, so accessAddr=0 and both flags are 0 after reset.
- R10: loadFlag is 1 for exactly the cycle after a loading edge. advanceFlag is 1 for exactly the cycle after a stepping edge. Both are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| extAddr | input | ADDR_W | External start address |
| procStrobeN | input | 1 | Processor load strobe, active low, gated by masterEnN |
| ctrlStrobeN | input | 1 | Controller load strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| masterEnN | input | 1 | Master enable, active low; gates only the processor strobe |
| interleaveMode | input | 1 | Static: 1 = XOR order, 0 = linear order |
| accessAddr | output | ADDR_W | Current access address |
| loadFlag | output | 1 | Previous edge loaded an address |
| advanceFlag | output | 1 | Previous edge stepped the burst |

## Verification
A corrupted base register shows on accessAddr in the very next cycle after the faulty load. An upper-bit error then persists for the rest of the burst.

A wrong beat count shows at the first step as a wrong low pair of bits. The interleaved and linear orders agree only for some bases, so both modes are run from every base alignment.

A gating error in the strobe decode shows in one cycle, on both loadFlag and accessAddr.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } seqStrobes_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        procStrobeN,
  input  logic        ctrlStrobeN,
  input  logic        advanceN,
  input  logic        masterEnN,
  output seqStrobes_t strobes,
  output logic        loadFlag,
  output logic        advanceFlag
);
  logic procLoad;
  logic ctrlLoad;

  // The processor strobe needs the master enable; the controller strobe
  // yields to the processor strobe.
  assign procLoad     = !procStrobeN && !masterEnN;
  assign ctrlLoad     = !ctrlStrobeN && procStrobeN;
  assign strobes.load = procLoad || ctrlLoad;
  assign strobes.step = procStrobeN && ctrlStrobeN && !advanceN;

  always_ff @(posedge clk) begin
    if (rst) begin
      loadFlag    <= 1'b0;
      advanceFlag <= 1'b0;
    end else begin
      loadFlag    <= strobes.load;
      advanceFlag <= strobes.step;
    end
  end

  // R4: a processor-strobe edge never advances.
  p_adv_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    !procStrobeN |=> !advanceFlag);

  // R2: a blocked processor strobe loads nothing.
  p_blocked_r2: assert property (@(posedge clk) disable iff (rst)
    (!procStrobeN && masterEnN) |=> !loadFlag);

  // R10: a load edge raises loadFlag in the next cycle.
  p_load_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (!procStrobeN && !masterEnN) |=> loadFlag);
endmodule

// File: rtl/burst_seq_datapath.sv
module burst_seq_datapath
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobes_t       strobes,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              interleaveMode,
  output logic [ADDR_W-1:0] accessAddr
);
  localparam int BURST_W = $clog2(BURST_LEN);

  logic [ADDR_W-1:0]  baseAddr;
  logic [BURST_W-1:0] beatCnt;
  logic [BURST_W-1:0] lowBits;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseAddr <= '0;
      beatCnt  <= '0;
    end else if (strobes.load) begin
      baseAddr <= extAddr;
      beatCnt  <= '0;
    end else if (strobes.step) begin
      beatCnt  <= beatCnt + 1'b1;
    end
  end

  // The low bits wrap inside the burst group; no carry reaches the upper bits.
  always_comb begin
    if (interleaveMode) lowBits = baseAddr[BURST_W-1:0] ^ beatCnt;
    else                lowBits = baseAddr[BURST_W-1:0] + beatCnt;
  end

  assign accessAddr = {baseAddr[ADDR_W-1:BURST_W], lowBits};

  // R1: a load presents the external address on the next cycle.
  p_load_addr_r1: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> accessAddr == $past(extAddr));

  // R8: the upper bits hold until the next load.
  p_upper_const_r8: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> $stable(accessAddr[ADDR_W-1:BURST_W]));

  // R5: with no load and no step, the beat counter holds.
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!strobes.load && !strobes.step) |=> $stable(beatCnt));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              masterEnN,
  input  logic              interleaveMode,
  output logic [ADDR_W-1:0] accessAddr,
  output logic              loadFlag,
  output logic              advanceFlag
);
  seqStrobes_t strobes;

  burst_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .advanceN    (advanceN),
    .masterEnN   (masterEnN),
    .strobes     (strobes),
    .loadFlag    (loadFlag),
    .advanceFlag (advanceFlag)
  );

  burst_seq_datapath #(
    .ADDR_W    (ADDR_W),
    .BURST_LEN (BURST_LEN)
  ) u_dp (
    .clk            (clk),
    .rst            (rst),
    .strobes        (strobes),
    .extAddr        (extAddr),
    .interleaveMode (interleaveMode),
    .accessAddr     (accessAddr)
  );
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] extAddr;
  logic          procStrobeN, ctrlStrobeN, advanceN, masterEnN, interleaveMode;
  logic [AW-1:0] accessAddr;
  logic          loadFlag, advanceFlag;

  int checks = 0;
  int errors = 0;

  // Reference model state.
  logic [AW-1:0] mBase = '0;
  logic [1:0]    mCnt  = '0;
  logic          mLoad = 1'b0;
  logic          mStep = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BURST_LEN(4)) u_dut (
    .clk(clk), .rst(rst), .extAddr(extAddr), .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN), .masterEnN(masterEnN),
    .interleaveMode(interleaveMode), .accessAddr(accessAddr),
    .loadFlag(loadFlag), .advanceFlag(advanceFlag)
  );

  function automatic logic [AW-1:0] expAddr();
    logic [1:0] lo;
    lo = interleaveMode ? (mBase[1:0] ^ mCnt) : (mBase[1:0] + mCnt);
    return {mBase[AW-1:2], lo};
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic p, input logic c, input logic a,
                     input logic e, input logic [AW-1:0] ad, input string tag);
    logic ld, st;
    string t;
    @(negedge clk);
    procStrobeN = p; ctrlStrobeN = c; advanceN = a; masterEnN = e; extAddr = ad;
    ld = (!p && !e) || (!c && p);
    st = p && c && !a;
    if (tag != "") t = tag;
    else if (ld && !p) t = "R1";
    else if (ld) t = "R3";
    else if (st) t = interleaveMode ? "R6" : "R7";
    else t = "R5";
    if (ld) begin mBase = ad; mCnt = 2'd0; end
    else if (st) mCnt = mCnt + 2'd1;
    mLoad = ld; mStep = st;
    @(posedge clk); #1;
    check(t, accessAddr, expAddr());
    check("R10 load", {{(AW-1){1'b0}}, loadFlag}, {{(AW-1){1'b0}}, mLoad});
    check("R10 adv", {{(AW-1){1'b0}}, advanceFlag}, {{(AW-1){1'b0}}, mStep});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; procStrobeN = 1; ctrlStrobeN = 1; advanceN = 1; masterEnN = 1;
    extAddr = '0; interleaveMode = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R9 addr", accessAddr, '0);
    check("R9 flags", {{(AW-2){1'b0}}, loadFlag, advanceFlag}, '0);
    @(negedge clk); rst = 1'b0;

    // R4: a processor load with advance low does not step.
    cyc(0, 1, 0, 0, 18'h12345, "R4");
    // R6 and R8: interleaved burst, then wrap past the fourth beat.
    for (int i = 0; i < 6; i++) cyc(1, 1, 0, 1, 18'h3FFFF, "R8");
    // R5: suspend.
    cyc(1, 1, 1, 0, 18'h00000, "R5");
    // R2: blocked processor load.
    cyc(0, 1, 0, 1, 18'h2AAAA, "R2");
    // R2: controller load ignores the master enable.
    cyc(1, 0, 1, 1, 18'h0ABC7, "R2");
    // R3: controller strobe low with the processor strobe also low and blocked.
    cyc(0, 0, 1, 1, 18'h11111, "R3");
    // R7: linear order from base 3 across the wrap.
    interleaveMode = 1'b0;
    cyc(1, 0, 0, 0, 18'h00FF3, "R3");
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, 18'h0, "R7");

    // Random traffic in both modes.
    for (int m = 0; m < 2; m++) begin
      interleaveMode = (m == 0);
      for (int i = 0; i < 600; i++)
        cyc(($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 5) < 2,
            ($urandom % 5) == 0, AW'($urandom), "");
    end

    // R9: reset mid-burst.
    @(negedge clk); rst = 1'b1; procStrobeN = 1; ctrlStrobeN = 1; advanceN = 0;
    @(posedge clk); #1;
    check("R9 mid", accessAddr, '0);
    mBase = '0; mCnt = '0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule